// File: doc/BRIEF.md
# Write Buffer with Read-Miss Priority

This block sits between a cache and a single-ported memory. Pending writes enter a small queue: write-through stores, or dirty victim lines that the cache parks there before it asks for the refill. Read misses may pass these writes. Every read miss is checked against each live entry of the queue, and against a write that arrives in the same cycle. When a location matches, the newest matching value is returned straight from the queue and memory is not touched. When nothing matches, the read goes to memory at once, ahead of all queued writes. Queued writes drain in arrival order, and only in cycles where no read miss is waiting.

The cache drives a valid/ready write stream (`wr_*`) and a valid/ready read-miss stream (`rd_*`). A transfer happens on a cycle where valid and ready are both high. A source that raises valid keeps it high, with its payload unchanged, until ready is seen. `wr_ready` drops only when the queue is full. `rd_ready` is high only while no read is in flight, and then only when the read can complete its step in that cycle: it either hits in the queue or finds memory ready. Read responses (`rsp_valid`, `rsp_data`) have no back-pressure; each one is a single-cycle pulse that the cache must take.

On the memory side there is one request channel. `mem_req_valid` carries the request and `mem_req_ready` is the memory's not-busy signal. `mem_req_we` marks a write. Read data comes back on `mem_rsp_valid`/`mem_rsp_data` in a later cycle.

Top module: `wbuf_rdprio`

## Requirements
- R1: While and after reset, the queue is empty: `wr_ready`=1, `mem_req_valid`=0 and `rsp_valid`=0. `rd_ready` follows `mem_req_ready`.
- R2: The queue holds DEPTH (default 4) entries, each an address and a data word. A write is stored on a cycle with `wr_valid`=1 and `wr_ready`=1. `wr_ready` is 0 exactly when DEPTH entries are held. A write offered while `wr_ready`=0 is not stored and never reaches memory.
- R3: Queued writes leave in the order they were stored, one per cycle with `mem_req_valid`=1 and `mem_req_ready`=1. Each carries `mem_req_we`=1 and its own address and data.
- R4: A write is presented to memory only when the queue is non-empty, no read is in flight and `rd_valid`=0. While presented, `mem_req_valid` does not depend on `mem_req_ready`.
- R5: When the read address equals the address of a live entry, the read is accepted without a memory read. In the next cycle `rsp_valid`=1 and `rsp_data` is the data of the youngest matching entry.
- R6: When no entry matches, in that same cycle `mem_req_valid`=1, `mem_req_we`=0 and `mem_req_addr`=`rd_addr`, and `rd_ready` equals `mem_req_ready`. The read is accepted when memory takes the request.
- R7: Only one memory read is in flight at a time. While it waits, `rd_ready`=0 and `mem_req_valid`=0. One cycle after `mem_rsp_valid`=1, `rsp_valid`=1 and `rsp_data` holds that cycle's `mem_rsp_data`.
- R8: A victim write stored in the same cycle as a non-matching read miss does not go to memory before that read. The read request is issued first, and the write drains after the read data has returned.
- R9: A write accepted in the same cycle as a read to the same address is part of that read's comparison and is treated as the youngest entry, so the read returns the new data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_valid | input | 1 | Write offered by the cache |
| wr_ready | output | 1 | Queue can take a write |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_valid | input | 1 | Read miss offered by the cache |
| rd_ready | output | 1 | Read miss accepted this cycle |
| rd_addr | input | AW | Read miss address |
| rsp_valid | output | 1 | Read data pulse to the cache |
| rsp_data | output | DW | Read data |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory can take a request |
| mem_req_we | output | 1 | 1 = write request, 0 = read request |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Write data of the request |
| mem_rsp_valid | input | 1 | Read data returned by memory |
| mem_rsp_data | input | DW | Returned read data |

## Verification
Three things can meet in one cycle: a write entering the queue, a read miss being checked, and the head of the queue competing for the memory port. Directed cycles place a write and a read to the same address together, and also a victim write together with a read to a different address. The random phase keeps a few addresses in play, toggles memory readiness and varies read latency, so these overlaps recur often. A behavioural queue-and-memory model in the bench predicts every port on every cycle, including which request owns the memory port and which value a forwarded read must return.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;
  typedef enum logic {
    ARB_IDLE   = 1'b0,
    ARB_RDWAIT = 1'b1
  } arb_state_e;
endpackage

// File: rtl/wbuf_store.sv
module wbuf_store #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic [AW-1:0] look_addr,
  output logic          full,
  output logic          empty,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          hit,
  output logic [DW-1:0] hit_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [AW-1:0]    ent_addr [DEPTH];
  logic [DW-1:0]    ent_data [DEPTH];
  logic [PW-1:0]    head_q, tail_q;
  logic [CW-1:0]    count_q;
  logic [DEPTH-1:0] slot_match;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push) tail_q <= wrap_inc(tail_q);
      if (pop)  head_q <= wrap_inc(head_q);
      count_q <= count_q + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      ent_addr[tail_q] <= push_addr;
      ent_data[tail_q] <= push_data;
    end
  end

  // per-slot address comparators
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    assign slot_match[g] = (ent_addr[g] == look_addr);
  end

  // walk from oldest to youngest so the last match wins
  always_comb begin
    int s;
    hit      = 1'b0;
    hit_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      s = (int'(head_q) + k) % DEPTH;
      if ((CW'(k) < count_q) && slot_match[s[PW-1:0]]) begin
        hit      = 1'b1;
        hit_data = ent_data[s[PW-1:0]];
      end
    end
    if (push && (push_addr == look_addr)) begin
      hit      = 1'b1;
      hit_data = push_data;
    end
  end

  assign full      = (count_q == CW'(DEPTH));
  assign empty     = (count_q == '0);
  assign head_addr = ent_addr[head_q];
  assign head_data = ent_data[head_q];

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count_q < CW'(DEPTH)));
  assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count_q != '0));
  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> (count_q == $past(count_q) + 1'b1));
endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_valid,
  input  logic [AW-1:0] rd_addr,
  input  logic          hit,
  input  logic [DW-1:0] hit_data,
  input  logic          empty,
  input  logic [AW-1:0] head_addr,
  input  logic [DW-1:0] head_data,
  input  logic          mem_req_ready,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          rd_ready,
  output logic          pop,
  output logic          mem_req_valid,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  arb_state_e state_q;
  logic idle, miss_go, drain_go, hit_fire, rsp_back;

  assign idle     = (state_q == ARB_IDLE);
  assign miss_go  = idle && rd_valid && !hit;
  assign drain_go = idle && !rd_valid && !empty;
  assign hit_fire = idle && rd_valid && hit;
  assign rsp_back = (state_q == ARB_RDWAIT) && mem_rsp_valid;

  assign mem_req_valid = miss_go || drain_go;
  assign mem_req_we    = drain_go;
  assign mem_req_addr  = miss_go ? rd_addr : head_addr;
  assign mem_req_wdata = head_data;
  assign rd_ready      = idle && (hit || mem_req_ready);
  assign pop           = drain_go && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ARB_IDLE;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (miss_go && mem_req_ready) state_q <= ARB_RDWAIT;
      else if (rsp_back)            state_q <= ARB_IDLE;
      rsp_valid <= hit_fire || rsp_back;
      if (hit_fire)      rsp_data <= hit_data;
      else if (rsp_back) rsp_data <= mem_rsp_data;
    end
  end

  assert_drain_yields_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_we) |-> (!rd_valid && !empty));
  assert_hit_no_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && hit) |-> !(mem_req_valid && !mem_req_we));
  assert_miss_issue_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready && !hit) |-> (mem_req_valid && !mem_req_we && mem_req_addr == rd_addr));
  assert_one_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_RDWAIT) |-> (!rd_ready && !mem_req_valid));
  assert_rsp_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(rd_valid && rd_ready && hit) || $past(mem_rsp_valid)));
endmodule

// File: rtl/wbuf_rdprio.sv
module wbuf_rdprio #(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int DEPTH = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  output logic          wr_ready,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_valid,
  output logic          rd_ready,
  input  logic [AW-1:0] rd_addr,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data
);
  logic          full, empty, push, pop, hit;
  logic [AW-1:0] head_addr;
  logic [DW-1:0] head_data, hit_data;

  assign wr_ready = !full;
  assign push     = wr_valid && !full;

  wbuf_store #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n),
    .push(push), .push_addr(wr_addr), .push_data(wr_data),
    .pop(pop), .look_addr(rd_addr),
    .full(full), .empty(empty),
    .head_addr(head_addr), .head_data(head_data),
    .hit(hit), .hit_data(hit_data)
  );

  wbuf_ctrl #(.AW(AW), .DW(DW)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .rd_valid(rd_valid), .rd_addr(rd_addr),
    .hit(hit), .hit_data(hit_data),
    .empty(empty), .head_addr(head_addr), .head_data(head_data),
    .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rd_ready(rd_ready), .pop(pop),
    .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );
endmodule

// File: tb/sim_wbuf_rdprio.sv
module sim_wbuf_rdprio;
  localparam int AW = 16, DW = 32, DEPTH = 4;
  localparam time CLK_PERIOD = 10ns;

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } ent_t;

  logic clk = 0, rst_n = 0;
  logic wv = 0, rv = 0, mrdy = 1, mrv = 0;
  logic [AW-1:0] wa = '0, ra = '0;
  logic [DW-1:0] wd = '0, mrd = '0;
  logic wr_ready, rd_ready, rsp_valid, mem_req_valid, mem_req_we;
  logic [DW-1:0] rsp_data, mem_req_wdata;
  logic [AW-1:0] mem_req_addr;

  wbuf_rdprio #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_valid(wv), .wr_ready(wr_ready), .wr_addr(wa), .wr_data(wd),
    .rd_valid(rv), .rd_ready(rd_ready), .rd_addr(ra),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mrdy), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mrv), .mem_rsp_data(mrd)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  ent_t q[$];
  logic [DW-1:0] mem [logic [AW-1:0]];
  bit m_busy = 0, m_rsp_v = 0;
  int m_lat = 0;
  logic [DW-1:0] m_rdata = '0, m_rsp_d = '0;
  logic s_mv, s_mwe; logic [AW-1:0] s_maddr;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    if (mem.exists(a)) return mem[a];
    return {16'hC0DE, a};
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      bad++;
      $display("FAIL R7 watchdog expired act=%0d exp=%0d", cyc, 60000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input bit iwv, input logic [AW-1:0] iwa, input logic [DW-1:0] iwd,
                      input bit irv, input logic [AW-1:0] ira, input bit imr,
                      output bit wacc, output bit racc);
    bit wfire, hit, e_rr, e_mv, e_we, nv;
    logic [AW-1:0] e_ma; logic [DW-1:0] hd, nd;
    @(negedge clk);
    wv = iwv; wa = iwa; wd = iwd; rv = irv; ra = ira; mrdy = imr;
    mrv = m_busy && (m_lat == 0); mrd = m_rdata;
    #1;
    wfire = iwv && (q.size() < DEPTH);
    hit = 0; hd = '0;
    foreach (q[i]) if (q[i].a == ira) begin hit = 1; hd = q[i].d; end
    if (wfire && iwa == ira) begin hit = 1; hd = iwd; end
    e_rr = !m_busy && (hit || imr);
    e_mv = 0; e_we = 0; e_ma = '0;
    if (!m_busy && irv && !hit) begin e_mv = 1; e_ma = ira; end
    else if (!m_busy && !irv && q.size() > 0) begin e_mv = 1; e_we = 1; e_ma = q[0].a; end
    chk(wr_ready == (q.size() < DEPTH), "R2 wr_ready", wr_ready, q.size() < DEPTH);
    chk(rd_ready == e_rr, "R6/R7 rd_ready", rd_ready, e_rr);
    chk(mem_req_valid == e_mv, "R4/R6/R7 mem_req_valid", mem_req_valid, e_mv);
    if (e_mv) begin
      chk(mem_req_we == e_we, "R3/R6 mem_req_we", mem_req_we, e_we);
      chk(mem_req_addr == e_ma, "R3/R6 mem_req_addr", mem_req_addr, e_ma);
      if (e_we) chk(mem_req_wdata == q[0].d, "R3 mem_req_wdata", mem_req_wdata, q[0].d);
    end
    chk(rsp_valid == m_rsp_v, "R5/R7 rsp_valid", rsp_valid, m_rsp_v);
    if (m_rsp_v) chk(rsp_data == m_rsp_d, "R5/R7 rsp_data", rsp_data, m_rsp_d);
    s_mv = mem_req_valid; s_mwe = mem_req_we; s_maddr = mem_req_addr;
    wacc = wfire; racc = irv && e_rr;
    @(posedge clk);
    nv = 0; nd = '0;
    if (irv && e_rr) begin
      if (hit) begin nv = 1; nd = hd; end
      else begin m_busy = 1; m_rdata = mem_rd(ira); m_lat = $urandom_range(2, 0); end
    end else if (m_busy) begin
      if (mrv) begin nv = 1; nd = mrd; m_busy = 0; end
      else m_lat--;
    end
    if (e_mv && e_we && imr) begin mem[q[0].a] = q[0].d; void'(q.pop_front()); end
    if (wfire) q.push_back('{a: iwa, d: iwd});
    m_rsp_v = nv; m_rsp_d = nd;
  endtask

  initial begin
    bit wa_ok, ra_ok;
    bit hwv, hrv;
    logic [AW-1:0] hwa, hra;
    logic [DW-1:0] hwd;
    // R1: reset state
    #(CLK_PERIOD*2 + 1ns);
    chk(wr_ready == 1, "R1 wr_ready in reset", wr_ready, 1);
    chk(rd_ready == 1, "R1 rd_ready in reset", rd_ready, 1);
    chk(mem_req_valid == 0, "R1 mem_req_valid in reset", mem_req_valid, 0);
    chk(rsp_valid == 0, "R1 rsp_valid in reset", rsp_valid, 0);
    @(negedge clk); rst_n = 1;

    // R2: fill with memory busy, fifth write refused
    for (int i = 0; i < 5; i++) begin
      step(1, 16'h0100 + 16'(i), 32'h1000 + i, 0, '0, 0, wa_ok, ra_ok);
      if (i == 4) chk(wa_ok == 0, "R2 write refused when full", wa_ok, 0);
    end
    // R3: drain in order (model checks each request)
    for (int i = 0; i < 6; i++) step(0, '0, '0, 0, '0, 1, wa_ok, ra_ok);

    // R5: two writes to one address, read returns the younger
    step(1, 16'h0200, 32'hAAAA0001, 0, '0, 0, wa_ok, ra_ok);
    step(1, 16'h0200, 32'hAAAA0002, 0, '0, 0, wa_ok, ra_ok);
    step(0, '0, '0, 1, 16'h0200, 0, wa_ok, ra_ok);
    chk(ra_ok == 1, "R5 hit accepted with memory busy", ra_ok, 1);
    step(0, '0, '0, 0, '0, 0, wa_ok, ra_ok);
    chk(rsp_data == 32'hAAAA0002, "R5 youngest data forwarded", rsp_data, 32'hAAAA0002);

    // R6/R4: miss waits for memory, no drain while read is waiting
    step(0, '0, '0, 1, 16'h0300, 0, wa_ok, ra_ok);
    chk(s_mv && !s_mwe, "R4 read waiting blocks drain", {s_mv, s_mwe}, 2'b10);
    chk(ra_ok == 0, "R6 miss held while memory busy", ra_ok, 0);
    step(0, '0, '0, 1, 16'h0300, 1, wa_ok, ra_ok);
    chk(ra_ok == 1, "R6 miss accepted when memory ready", ra_ok, 1);
    for (int i = 0; i < 8; i++) step(0, '0, '0, 0, '0, 1, wa_ok, ra_ok);

    // R9: same-cycle write and read to the same address
    step(1, 16'h0400, 32'hBEEF0004, 1, 16'h0400, 1, wa_ok, ra_ok);
    chk(!(s_mv && !s_mwe), "R9 no memory read for same-cycle match", s_mv, 0);
    step(0, '0, '0, 0, '0, 0, wa_ok, ra_ok);
    chk(rsp_valid && rsp_data == 32'hBEEF0004, "R9 same-cycle write forwarded", rsp_data, 32'hBEEF0004);
    for (int i = 0; i < 3; i++) step(0, '0, '0, 0, '0, 1, wa_ok, ra_ok);

    // R8: victim parked, refill read goes first
    step(1, 16'h0500, 32'hD1D1D1D1, 1, 16'h0600, 1, wa_ok, ra_ok);
    chk(s_mv && !s_mwe && s_maddr == 16'h0600, "R8 refill read before victim write", s_maddr, 16'h0600);
    for (int i = 0; i < 8; i++) step(0, '0, '0, 0, '0, 1, wa_ok, ra_ok);
    chk(mem_rd(16'h0500) == 32'hD1D1D1D1, "R8 victim written afterwards", mem_rd(16'h0500), 32'hD1D1D1D1);

    // random traffic, held payloads until accepted
    hwv = 0; hrv = 0; hwa = '0; hra = '0; hwd = '0;
    for (int i = 0; i < 3000; i++) begin
      if (!hwv && ($urandom_range(2, 0) == 0)) begin
        hwv = 1; hwa = 16'(16'h0700 + $urandom_range(3, 0)); hwd = $urandom;
      end
      if (!hrv && ($urandom_range(3, 0) == 0)) begin
        hrv = 1; hra = 16'(16'h0700 + $urandom_range(5, 0));
      end
      step(hwv, hwa, hwd, hrv, hra, ($urandom_range(3, 0) != 0), wa_ok, ra_ok);
      if (wa_ok) hwv = 0;
      if (ra_ok) hrv = 0;
    end
    for (int i = 0; i < 12; i++) step(0, '0, '0, 0, '0, 1, wa_ok, ra_ok);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule